// File: doc/BRIEF.md
# Revocation Bitmap Load Filter

This block sits on the capability-load path of a small in-order core and stops dangling pointers from entering the register file. It keeps one revocation bit for each 8-byte granule of on-chip SRAM. The allocator sets the bits that cover a region when it frees that region. It clears them again once the memory may be reused.

Each capability load passes through a single registered stage. When the loaded value is a tagged capability whose base address falls inside the SRAM window, the block looks up the bit for the granule that holds that base. If the bit is set, the block drops the validity tag before the value is written back. The 64 data bits pass through untouched. Plain data loads, and values whose tag is already clear, pass through without any lookup.

Software reaches the bitmap through a word-wide port. A masked write changes only the selected bits, which supports read-modify-write. A read returns a whole 32-bit word one cycle later.

Top module: `revoke_filter_top`

## Requirements
- R1: After reset every bitmap word reads as zero and `outValid` is low.
- R2: A load presented with `ldValid` high appears on the outputs exactly one cycle later with `outValid` high and `outData` equal to `ldData`. Cycles without a load give `outValid` low.
- R3: A load with `ldIsCap`=1 and `ldTag`=1 whose granule bit is 1 leaves with `outTag`=0 and `outRevoked`=1.
- R4: A tagged capability load whose granule bit is 0 keeps `outTag`=1, with `outRevoked`=0.
- R5: A load with `ldTag`=0 leaves with `outTag`=0 and `outRevoked`=0, whatever the bitmap holds.
- R6: A load with `ldIsCap`=0 (plain data) keeps its incoming tag, with `outRevoked`=0, even at a revoked address.
- R7: A base address below `SRAM_BASE` or at or above `SRAM_BASE+SRAM_BYTES` is treated as not revoked.
- R8: The granule index is g = (base - `SRAM_BASE`) >> 3. It maps to bit g mod 32 of bitmap word g / 32, so all eight byte addresses of a granule share one bit.
- R9: A write (`swValid`=1, `swWrite`=1) replaces only the bits of word `swIdx` where `swWmask` is 1, taking them from `swWdata`. A read (`swValid`=1, `swWrite`=0) returns that word on `swRdata` one cycle later, with `swRvalid` high.
- R10: A load that meets a bitmap write in the same cycle is judged against the bitmap contents from before that write. The next load sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swValid | input | 1 | Software bitmap access request |
| swWrite | input | 1 | 1 = masked write, 0 = read |
| swIdx | input | IDX_W | Bitmap word index |
| swWdata | input | 32 | Write data |
| swWmask | input | 32 | Per-bit write enable |
| swRdata | output | 32 | Read data, one cycle after the request |
| swRvalid | output | 1 | Read data valid |
| ldValid | input | 1 | Load data returning this cycle |
| ldIsCap | input | 1 | Load is a capability load |
| ldTag | input | 1 | Incoming validity tag |
| ldBase | input | 32 | Decoded base address of the loaded capability |
| ldData | input | 64 | Loaded 64-bit value |
| outValid | output | 1 | Filtered load valid |
| outData | output | 64 | Filtered load value |
| outTag | output | 1 | Tag after the revocation check |
| outRevoked | output | 1 | Tag was dropped because of revocation |

## Verification
The hardest case to reach from the ports is the race between a bitmap write and a capability load that points into the same granule in the same cycle. Only that cycle shows whether the lookup reads old or new contents. The stimulus drives the write request and the load in one cycle, at a granule that is about to be marked. It then repeats the load on the following cycle, so that both sides of the ordering are observed. Granules at both ends of the window, and addresses just outside it, are marked and loaded to cover the index arithmetic.

// File: rtl/revoke_pkg.sv
package revoke_pkg;
  localparam int GRAN_SHIFT = 3;   // 8-byte granules
  localparam int MAP_W      = 32;  // bitmap word width
  localparam int BIT_SEL_W  = 5;   // log2(MAP_W)
  localparam int CAP_W      = 64;  // capability payload width

  typedef struct packed {
    logic capture;  // a load returns this cycle
    logic lookup;   // the load needs a bitmap lookup
    logic wr;       // masked software write
    logic rd;       // software read
  } revStrobe_t;
endpackage

// File: rtl/revoke_ctrl.sv
module revoke_ctrl
  import revoke_pkg::*;
#(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter int          SRAM_BYTES = 4096,
  parameter int          IDX_W      = 4
) (
  input  logic                 ldValid,
  input  logic                 ldIsCap,
  input  logic                 ldTag,
  input  logic [31:0]          ldBase,
  input  logic                 swValid,
  input  logic                 swWrite,
  output revStrobe_t           strobe,
  output logic [IDX_W-1:0]     lookupWord,
  output logic [BIT_SEL_W-1:0] lookupBit
);
  localparam logic [31:0] WIN_SIZE = SRAM_BYTES;
  localparam int WORD_LSB = GRAN_SHIFT + BIT_SEL_W;

  logic [31:0] offset;
  logic        inWindow;

  always_comb begin
    offset     = ldBase - SRAM_BASE;
    inWindow   = (ldBase >= SRAM_BASE) && (offset < WIN_SIZE);
    lookupBit  = offset[GRAN_SHIFT +: BIT_SEL_W];
    lookupWord = offset[WORD_LSB +: IDX_W];
  end

  always_comb begin
    strobe         = '0;
    strobe.capture = ldValid;
    strobe.lookup  = ldValid && ldIsCap && ldTag && inWindow;
    strobe.wr      = swValid && swWrite;
    strobe.rd      = swValid && !swWrite;
  end
endmodule

// File: rtl/revoke_datapath.sv
module revoke_datapath
  import revoke_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  revStrobe_t           strobe,
  input  logic [IDX_W-1:0]     lookupWord,
  input  logic [BIT_SEL_W-1:0] lookupBit,
  input  logic [IDX_W-1:0]     swIdx,
  input  logic [MAP_W-1:0]     swWdata,
  input  logic [MAP_W-1:0]     swWmask,
  input  logic [CAP_W-1:0]     ldData,
  input  logic                 ldTag,
  output logic                 outValid,
  output logic [CAP_W-1:0]     outData,
  output logic                 outTag,
  output logic                 outRevoked,
  output logic [MAP_W-1:0]     swRdata,
  output logic                 swRvalid
);
  logic [MAP_W-1:0] mapWord [WORDS];
  logic [MAP_W-1:0] selWord;
  logic             hitBit;
  logic             revokeNow;

  // Each bitmap word has its own masked write enable.
  for (genvar w = 0; w < WORDS; w++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mapWord[w] <= '0;
      end else if (strobe.wr && (swIdx == IDX_W'(w))) begin
        mapWord[w] <= (mapWord[w] & ~swWmask) | (swWdata & swWmask);
      end
    end
  end

  // The lookup reads the registered array, so it sees pre-write contents.
  always_comb begin
    selWord   = mapWord[lookupWord];
    hitBit    = selWord[lookupBit];
    revokeNow = strobe.lookup && hitBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outTag     <= 1'b0;
      outRevoked <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outData    <= ldData;
        outTag     <= ldTag && !revokeNow;
        outRevoked <= revokeNow;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swRdata  <= '0;
      swRvalid <= 1'b0;
    end else begin
      swRvalid <= strobe.rd;
      if (strobe.rd) swRdata <= mapWord[swIdx];
    end
  end

  AST_REVOKE_DROPS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRevoked) |-> !outTag); // R3

  AST_TAG_NOT_CREATED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag) |-> $past(ldTag)); // R5

  AST_DATA_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData == $past(ldData))); // R2

  AST_REVOKE_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRevoked) |-> $past(strobe.lookup)); // R6

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    swRvalid |-> $past(strobe.rd)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !outValid); // R2
endmodule

// File: rtl/revoke_filter_top.sv
module revoke_filter_top
  import revoke_pkg::*;
#(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter int          SRAM_BYTES = 4096,
  localparam int         GRANULES   = SRAM_BYTES >> GRAN_SHIFT,
  localparam int         WORDS      = GRANULES / MAP_W,
  localparam int         IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swValid,
  input  logic             swWrite,
  input  logic [IDX_W-1:0] swIdx,
  input  logic [31:0]      swWdata,
  input  logic [31:0]      swWmask,
  output logic [31:0]      swRdata,
  output logic             swRvalid,
  input  logic             ldValid,
  input  logic             ldIsCap,
  input  logic             ldTag,
  input  logic [31:0]      ldBase,
  input  logic [63:0]      ldData,
  output logic             outValid,
  output logic [63:0]      outData,
  output logic             outTag,
  output logic             outRevoked
);
  revStrobe_t           strobe;
  logic [IDX_W-1:0]     lookupWord;
  logic [BIT_SEL_W-1:0] lookupBit;

  revoke_ctrl #(
    .SRAM_BASE (SRAM_BASE),
    .SRAM_BYTES(SRAM_BYTES),
    .IDX_W     (IDX_W)
  ) uCtrl (
    .ldValid   (ldValid),
    .ldIsCap   (ldIsCap),
    .ldTag     (ldTag),
    .ldBase    (ldBase),
    .swValid   (swValid),
    .swWrite   (swWrite),
    .strobe    (strobe),
    .lookupWord(lookupWord),
    .lookupBit (lookupBit)
  );

  revoke_datapath #(
    .WORDS(WORDS),
    .IDX_W(IDX_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lookupWord(lookupWord),
    .lookupBit (lookupBit),
    .swIdx     (swIdx),
    .swWdata   (swWdata),
    .swWmask   (swWmask),
    .ldData    (ldData),
    .ldTag     (ldTag),
    .outValid  (outValid),
    .outData   (outData),
    .outTag    (outTag),
    .outRevoked(outRevoked),
    .swRdata   (swRdata),
    .swRvalid  (swRvalid)
  );
endmodule

// File: tb/tb_revoke_filter_top.sv
module tb_revoke_filter_top;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam int BYTES = 4096;
  localparam int WORDS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swValid = 0, swWrite = 0;
  logic [3:0] swIdx = '0;
  logic [31:0] swWdata = '0, swWmask = '0;
  logic [31:0] swRdata;
  logic swRvalid;
  logic ldValid = 0, ldIsCap = 0, ldTag = 0;
  logic [31:0] ldBase = '0;
  logic [63:0] ldData = '0;
  logic outValid, outTag, outRevoked;
  logic [63:0] outData;

  always #2.5 clk = ~clk;

  revoke_filter_top #(.SRAM_BASE(BASE), .SRAM_BYTES(BYTES)) dut (
    .clk(clk), .rstN(rstN), .swValid(swValid), .swWrite(swWrite), .swIdx(swIdx),
    .swWdata(swWdata), .swWmask(swWmask), .swRdata(swRdata), .swRvalid(swRvalid),
    .ldValid(ldValid), .ldIsCap(ldIsCap), .ldTag(ldTag), .ldBase(ldBase),
    .ldData(ldData), .outValid(outValid), .outData(outData), .outTag(outTag),
    .outRevoked(outRevoked));

  int checks = 0;
  int failures = 0;
  logic [31:0] refMap [WORDS];

  typedef struct {
    logic [63:0] data;
    logic tag;
    logic rev;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic modelRevoked(input logic [31:0] base, input logic isCap, input logic tag);
    logic [31:0] off;
    off = base - BASE;
    if (!(isCap && tag)) return 1'b0;
    if (base < BASE || off >= BYTES) return 1'b0;
    return refMap[off[11:8]][off[7:3]];
  endfunction

  // Monitor: pops one expected item per valid output.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", 64'(outValid), 64'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(outData == e.data, {e.req, " data"}, outData, e.data);
        check(outTag == e.tag, {e.req, " tag"}, 64'(outTag), 64'(e.tag));
        check(outRevoked == e.rev, {e.req, " revoked"}, 64'(outRevoked), 64'(e.rev));
      end
    end
  end

  // Drive one load for one cycle; caller continues at the next negedge.
  task automatic sendLoad(input logic [31:0] base, input logic isCap, input logic tag,
                          input logic [63:0] data, input string req);
    expItem_t e;
    logic r;
    r = modelRevoked(base, isCap, tag);
    e.data = data; e.tag = tag && !r; e.rev = r; e.req = req;
    expQ.push_back(e);
    ldValid = 1; ldIsCap = isCap; ldTag = tag; ldBase = base; ldData = data;
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    ldValid = 0; ldIsCap = 0; ldTag = 0;
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b0, req, 64'(outValid), 64'd0);
  endtask

  task automatic writeWord(input logic [3:0] idx, input logic [31:0] data, input logic [31:0] mask);
    swValid = 1; swWrite = 1; swIdx = idx; swWdata = data; swWmask = mask;
    @(negedge clk);
    swValid = 0; swWrite = 0;
    refMap[idx] = (refMap[idx] & ~mask) | (data & mask);
  endtask

  task automatic readWord(input logic [3:0] idx, input string req);
    swValid = 1; swWrite = 0; swIdx = idx;
    @(negedge clk);
    swValid = 0;
    check(swRvalid == 1'b1, {req, " rvalid"}, 64'(swRvalid), 64'd1);
    check(swRdata == refMap[idx], {req, " rdata"}, 64'(swRdata), 64'(refMap[idx]));
  endtask

  function automatic logic [31:0] granAddr(input int g, input int byteOff);
    return BASE + 32'(g * 8 + byteOff);
  endfunction

  task automatic finishRun();
    check(expQ.size() == 0, "R2 pending outputs", 64'(expQ.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) refMap[i] = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", 64'(outValid), 64'd0);
    rstN = 1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", 64'(outValid), 64'd0);
    for (int i = 0; i < WORDS; i++) readWord(4'(i), "R1 word clear");

    // R9: masked writes touch only selected bits.
    writeWord(4'd2, 32'hFFFF_FFFF, 32'h0000_00F0);
    readWord(4'd2, "R9 masked set");
    writeWord(4'd2, 32'h0000_0000, 32'h0000_0010);
    readWord(4'd2, "R9 masked clear");
    check(refMap[2] == 32'hE0, "R9 model", 64'(refMap[2]), 64'hE0);

    // R3/R8: granule 69 = word 2 bit 5, all 8 bytes share the bit.
    sendLoad(granAddr(69, 0), 1, 1, 64'h1111_2222_3333_4444, "R3 revoked base");
    sendLoad(granAddr(69, 7), 1, 1, 64'h5555_6666_7777_8888, "R8 last byte of granule");
    sendLoad(granAddr(70, 0), 1, 1, 64'h9999_AAAA_BBBB_CCCC, "R8 next granule bit6");
    sendLoad(granAddr(68, 7), 1, 1, 64'hDDDD_EEEE_FFFF_0000, "R4 unmarked neighbour");
    idle("R2 idle after burst");

    // R5 and R6 at a revoked address.
    sendLoad(granAddr(69, 3), 1, 0, 64'h0123_4567_89AB_CDEF, "R5 untagged cap");
    sendLoad(granAddr(69, 3), 0, 1, 64'hFEDC_BA98_7654_3210, "R6 plain data load");
    sendLoad(granAddr(69, 3), 0, 0, 64'h0F0F_0F0F_F0F0_F0F0, "R6 plain untagged");
    idle("R2 idle");

    // R7 and window ends.
    writeWord(4'd0, 32'h0000_0001, 32'h0000_0001);
    writeWord(4'd15, 32'h8000_0000, 32'h8000_0000);
    sendLoad(BASE, 1, 1, 64'hA0, "R8 first granule");
    sendLoad(BASE + 32'(BYTES - 1), 1, 1, 64'hA1, "R8 last granule");
    sendLoad(BASE + 32'(BYTES), 1, 1, 64'hA2, "R7 just above window");
    sendLoad(BASE - 32'd8, 1, 1, 64'hA3, "R7 just below window");
    sendLoad(32'h0000_0000, 1, 1, 64'hA4, "R7 far outside");
    idle("R2 idle");

    // R10: write and load to the same granule in one cycle.
    swValid = 1; swWrite = 1; swIdx = 4'd7; swWdata = 32'h0000_0200; swWmask = 32'h0000_0200;
    sendLoad(granAddr(7 * 32 + 9, 2), 1, 1, 64'hB0, "R10 same-cycle pre-write view");
    swValid = 0; swWrite = 0;
    refMap[7] = refMap[7] | 32'h0000_0200;
    sendLoad(granAddr(7 * 32 + 9, 2), 1, 1, 64'hB1, "R10 following load sees mark");
    idle("R2 idle");

    // R4: unmarking for reuse restores the tag.
    writeWord(4'd2, 32'h0, 32'hFFFF_FFFF);
    sendLoad(granAddr(69, 0), 1, 1, 64'hC0, "R4 unmarked after reuse");
    idle("R2 idle");
    readWord(4'd7, "R9 read after race");

    finishRun();
  end
endmodule